// File: doc/BRIEF.md
# Camera Pixel Capture Front End

This block sits on the pixel-clock side of a parallel camera port that presents one pixel per clock as a luminance byte and a chrominance byte side by side (YUV 4:2:2 over a 16-bit bus). It decides which samples are image data. A sample counts only when the line-valid input is at its selected active level. Within such a line, a sample that carries the fixed blanking code on both lanes is dropped.

Kept pixels are paired into 32-bit words and placed in a small show-ahead FIFO, which a host reader drains through a valid/read-enable pair. The first word of each frame is tagged. Overflow of the FIFO is recorded in a sticky flag. Pixel and line counters give the shape of the last completed line and of the last completed frame. A one-cycle end-of-frame pulse marks the vertical sync edge that closes a frame.

Top module: `cam_capture_top`

## Requirements
- R1: On every rising clock edge both lanes are sampled. A kept pixel is the 16-bit value {UV, Y}, with the Y byte in bits 7:0 and the UV byte in bits 15:8.
- R2: With `href_active_high_i`=1 a sample is inside a line when `cam_href_i`=1. With `href_active_high_i`=0 it is inside a line when `cam_href_i`=0. Samples outside a line are neither stored nor counted.
- R3: Inside a line, a sample with Y=0x10 and UV=0x80 together is blanking. It is neither stored nor counted.
- R4: Two consecutive kept pixels form one word. The earlier pixel goes in bits 15:0 and the later pixel in bits 31:16.
- R5: A single unpaired pixel left when a line ends is discarded, and the next line pairs from its own first pixel. A rising edge of `cam_vsync_i` also discards any unpaired pixel.
- R6: The first word formed after a rising edge of `cam_vsync_i` is read out with `rd_sof_o`=1. Every other word is read out with `rd_sof_o`=0.
- R7: The FIFO holds `FIFO_DEPTH` words in arrival order. `rd_valid_o` is high whenever it is non-empty, with the oldest word on `rd_data_o`/`rd_sof_o`. `rd_en_i` removes that word. `rd_en_i` while empty has no effect.
- R8: A word formed while the FIFO is full is dropped and sets `overflow_o`. The words already stored are unchanged, and `overflow_o` stays set until reset.
- R9: When a line ends, `line_pixels_o` takes the number of pixels kept in that line and `line_idx_o` increments. A rising edge of `cam_vsync_i` clears `line_idx_o`.
- R10: On a rising edge of `cam_vsync_i`, `frame_lines_o` takes the value of `line_idx_o`. `eof_o` pulses for one cycle if at least one line ended since the previous edge.
- R11: After reset the FIFO is empty, `overflow_o` and `eof_o` are 0, and all counters read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cam_y_i | input | 8 | Luminance lane |
| cam_uv_i | input | 8 | Chrominance lane |
| cam_href_i | input | 1 | Line-valid reference from the camera |
| cam_vsync_i | input | 1 | Vertical sync; rising edge starts a frame |
| href_active_high_i | input | 1 | 1: line-valid active high, 0: active low |
| rd_en_i | input | 1 | Host removes the word at the FIFO head |
| rd_valid_o | output | 1 | FIFO holds at least one word |
| rd_data_o | output | 32 | Word at the FIFO head |
| rd_sof_o | output | 1 | Head word is the first of a frame |
| overflow_o | output | 1 | Sticky: a word was dropped on a full FIFO |
| line_pixels_o | output | COL_W | Kept pixels in the last completed line |
| line_idx_o | output | ROW_W | Lines completed in the current frame |
| frame_lines_o | output | ROW_W | Lines in the last completed frame |
| eof_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench builds the block with `FIFO_DEPTH`=4 and the default window limits of 356 columns and 292 rows. The shallow FIFO becomes full after one line of twelve kept pixels. This brings the dropped-word path and the sticky flag within reach in a short run, and the bench then checks that the four stored words survive intact. The window limits stay at their defaults because the short test lines never approach saturation. The counter widths are therefore the ones a full-size frame would use.

// File: rtl/cam_cap_pkg.sv
package cam_cap_pkg;
    localparam int unsigned LANE_W = 8;
    localparam int unsigned PIX_W  = 2 * LANE_W;
    localparam int unsigned WORD_W = 2 * PIX_W;

    localparam logic [LANE_W-1:0] BLANK_Y  = 8'h10;
    localparam logic [LANE_W-1:0] BLANK_UV = 8'h80;

    typedef struct packed {
        logic              vld;
        logic [PIX_W-1:0]  pix;
        logic              act_prev;
        logic              vs_prev;
        logic              vs_rise;
        logic              line_end;
    } qual_st_t;

    typedef struct packed {
        logic              half;
        logic [PIX_W-1:0]  low;
        logic              sof_pend;
        logic              wvld;
        logic [WORD_W-1:0] word;
        logic              wsof;
    } pack_st_t;
endpackage

// File: rtl/cam_line_qualify.sv
module cam_line_qualify
    import cam_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LANE_W-1:0] y_i,
    input  logic [LANE_W-1:0] uv_i,
    input  logic              href_i,
    input  logic              vsync_i,
    input  logic              act_high_i,
    output logic              pix_vld_o,
    output logic [PIX_W-1:0]  pix_o,
    output logic              vs_rise_o,
    output logic              line_end_o
);
    qual_st_t st_d, st_q;
    logic     act;
    logic     blank;

    always_comb begin
        act   = act_high_i ? href_i : ~href_i;
        blank = (y_i == BLANK_Y) && (uv_i == BLANK_UV);
        st_d           = st_q;
        st_d.vld       = act && !blank;
        st_d.pix       = {uv_i, y_i};
        st_d.act_prev  = act;
        st_d.vs_prev   = vsync_i;
        st_d.vs_rise   = vsync_i && !st_q.vs_prev;
        st_d.line_end  = st_q.act_prev && !act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pix_vld_o  = st_q.vld;
    assign pix_o      = st_q.pix;
    assign vs_rise_o  = st_q.vs_rise;
    assign line_end_o = st_q.line_end;

    // A line ends on an out-of-line sample, so no pixel rides with it (R9)
    p_end_no_pixel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        line_end_o |-> !pix_vld_o);
    // Sync edges are single-cycle events (R10)
    p_vs_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise_o |=> !vs_rise_o);
endmodule

// File: rtl/cam_pixel_pack.sv
module cam_pixel_pack
    import cam_cap_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pix_vld_i,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              vs_rise_i,
    input  logic              line_end_i,
    output logic              word_vld_o,
    output logic [WORD_W-1:0] word_o,
    output logic              word_sof_o
);
    pack_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.wvld = 1'b0;
        if (vs_rise_i) begin
            st_d.half     = 1'b0;
            st_d.sof_pend = 1'b1;
        end else if (line_end_i) begin
            st_d.half = 1'b0;
        end else if (pix_vld_i) begin
            if (!st_q.half) begin
                st_d.low  = pix_i;
                st_d.half = 1'b1;
            end else begin
                st_d.half     = 1'b0;
                st_d.wvld     = 1'b1;
                st_d.word     = {pix_i, st_q.low};
                st_d.wsof     = st_q.sof_pend;
                st_d.sof_pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign word_vld_o = st_q.wvld;
    assign word_o     = st_q.word;
    assign word_sof_o = st_q.wsof;

    p_no_blank_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pix_vld_i |-> (pix_i != {BLANK_UV, BLANK_Y}));
    p_pair_emits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld_i && st_q.half && !vs_rise_i && !line_end_i) |=> word_vld_o);
    p_end_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end_i || vs_rise_i) |=> !st_q.half);
    p_sof_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_vld_i && st_q.half && !vs_rise_i && !line_end_i) |=> !st_q.sof_pend);
endmodule

// File: rtl/cam_word_fifo.sv
module cam_word_fifo #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned DW    = 33
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [DW-1:0] push_data_i,
    input  logic          pop_i,
    output logic          valid_o,
    output logic [DW-1:0] head_o,
    output logic          overflow_o
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] cnt;
        logic          ovf;
    } fifo_st_t;

    fifo_st_t       st_d, st_q;
    logic [DW-1:0]  mem_q [DEPTH];
    logic           full, empty, do_push, do_pop;

    always_comb begin
        full    = (st_q.cnt == FULL);
        empty   = (st_q.cnt == '0);
        do_push = push_i && !full;
        do_pop  = pop_i && !empty;
        st_d    = st_q;
        if (push_i && full) st_d.ovf = 1'b1;
        if (do_push) st_d.wr_ptr = (st_q.wr_ptr == LAST) ? '0 : st_q.wr_ptr + 1'b1;
        if (do_pop)  st_d.rd_ptr = (st_q.rd_ptr == LAST) ? '0 : st_q.rd_ptr + 1'b1;
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem_q[st_q.wr_ptr] <= push_data_i;
    end

    assign valid_o    = !empty;
    assign head_o     = mem_q[st_q.rd_ptr];
    assign overflow_o = st_q.ovf;

    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL);
    p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && empty && !push_i) |=> (st_q.cnt == '0));
    p_full_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !pop_i) |=> (st_q.cnt == FULL) && overflow_o);
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);
endmodule

// File: rtl/cam_frame_count.sv
module cam_frame_count #(
    parameter int unsigned MAX_COLS = 356,
    parameter int unsigned MAX_ROWS = 292,
    parameter int unsigned COL_W    = $clog2(MAX_COLS + 1),
    parameter int unsigned ROW_W    = $clog2(MAX_ROWS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pix_vld_i,
    input  logic             vs_rise_i,
    input  logic             line_end_i,
    output logic [COL_W-1:0] line_pixels_o,
    output logic [ROW_W-1:0] line_idx_o,
    output logic [ROW_W-1:0] frame_lines_o,
    output logic             eof_o
);
    localparam logic [COL_W-1:0] COL_MAX = COL_W'(MAX_COLS);
    localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(MAX_ROWS);

    typedef struct packed {
        logic [COL_W-1:0] pix_cnt;
        logic [COL_W-1:0] line_pix;
        logic [ROW_W-1:0] line_cnt;
        logic [ROW_W-1:0] frame_lines;
        logic             eof;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.eof = 1'b0;
        if (vs_rise_i) begin
            st_d.frame_lines = st_q.line_cnt;
            st_d.eof         = (st_q.line_cnt != '0);
            st_d.line_cnt    = '0;
            st_d.pix_cnt     = '0;
        end else if (line_end_i) begin
            st_d.line_pix = st_q.pix_cnt;
            st_d.pix_cnt  = '0;
            if (st_q.line_cnt != ROW_MAX) st_d.line_cnt = st_q.line_cnt + 1'b1;
        end else if (pix_vld_i && st_q.pix_cnt != COL_MAX) begin
            st_d.pix_cnt = st_q.pix_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_pixels_o = st_q.line_pix;
    assign line_idx_o    = st_q.line_cnt;
    assign frame_lines_o = st_q.frame_lines;
    assign eof_o         = st_q.eof;

    p_vs_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        vs_rise_i |=> (line_idx_o == '0));
    p_line_steps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (line_end_i && !vs_rise_i && line_idx_o != ROW_MAX) |=> (line_idx_o == $past(line_idx_o) + 1'b1));
    p_eof_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        eof_o |=> !eof_o);
endmodule

// File: rtl/cam_capture_top.sv
module cam_capture_top
    import cam_cap_pkg::*;
#(
    parameter int unsigned FIFO_DEPTH = 8,
    parameter int unsigned MAX_COLS   = 356,
    parameter int unsigned MAX_ROWS   = 292,
    parameter int unsigned COL_W      = $clog2(MAX_COLS + 1),
    parameter int unsigned ROW_W      = $clog2(MAX_ROWS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cam_y_i,
    input  logic [7:0]        cam_uv_i,
    input  logic              cam_href_i,
    input  logic              cam_vsync_i,
    input  logic              href_active_high_i,
    input  logic              rd_en_i,
    output logic              rd_valid_o,
    output logic [31:0]       rd_data_o,
    output logic              rd_sof_o,
    output logic              overflow_o,
    output logic [COL_W-1:0]  line_pixels_o,
    output logic [ROW_W-1:0]  line_idx_o,
    output logic [ROW_W-1:0]  frame_lines_o,
    output logic              eof_o
);
    localparam int unsigned FDW = WORD_W + 1;

    logic              pix_vld, vs_rise, line_end;
    logic [PIX_W-1:0]  pix;
    logic              word_vld, word_sof;
    logic [WORD_W-1:0] word;
    logic [FDW-1:0]    head;

    cam_line_qualify u_qual (
        .clk        (clk),
        .rst_n      (rst_n),
        .y_i        (cam_y_i),
        .uv_i       (cam_uv_i),
        .href_i     (cam_href_i),
        .vsync_i    (cam_vsync_i),
        .act_high_i (href_active_high_i),
        .pix_vld_o  (pix_vld),
        .pix_o      (pix),
        .vs_rise_o  (vs_rise),
        .line_end_o (line_end)
    );

    cam_pixel_pack u_pack (
        .clk        (clk),
        .rst_n      (rst_n),
        .pix_vld_i  (pix_vld),
        .pix_i      (pix),
        .vs_rise_i  (vs_rise),
        .line_end_i (line_end),
        .word_vld_o (word_vld),
        .word_o     (word),
        .word_sof_o (word_sof)
    );

    cam_word_fifo #(.DEPTH(FIFO_DEPTH), .DW(FDW)) u_fifo (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (word_vld),
        .push_data_i ({word_sof, word}),
        .pop_i       (rd_en_i),
        .valid_o     (rd_valid_o),
        .head_o      (head),
        .overflow_o  (overflow_o)
    );

    cam_frame_count #(
        .MAX_COLS (MAX_COLS),
        .MAX_ROWS (MAX_ROWS),
        .COL_W    (COL_W),
        .ROW_W    (ROW_W)
    ) u_cnt (
        .clk           (clk),
        .rst_n         (rst_n),
        .pix_vld_i     (pix_vld),
        .vs_rise_i     (vs_rise),
        .line_end_i    (line_end),
        .line_pixels_o (line_pixels_o),
        .line_idx_o    (line_idx_o),
        .frame_lines_o (frame_lines_o),
        .eof_o         (eof_o)
    );

    assign rd_data_o = head[WORD_W-1:0];
    assign rd_sof_o  = head[WORD_W];
endmodule

// File: tb/tb_cam_capture_top.sv
module tb_cam_capture_top;
    localparam int unsigned DEPTH = 4;
    localparam int unsigned COL_W = 9;
    localparam int unsigned ROW_W = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] y = 8'h00, uv = 8'h00;
    logic href = 1'b0, vsync = 1'b0, pol = 1'b1, rd_en = 1'b0;
    logic rd_valid, rd_sof, overflow, eof;
    logic [31:0] rd_data;
    logic [COL_W-1:0] line_pixels;
    logic [ROW_W-1:0] line_idx, frame_lines;

    int tests = 0, fails = 0, eof_seen = 0;

    always #2 clk = ~clk;

    cam_capture_top #(.FIFO_DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .cam_y_i(y), .cam_uv_i(uv), .cam_href_i(href),
        .cam_vsync_i(vsync), .href_active_high_i(pol), .rd_en_i(rd_en),
        .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_sof_o(rd_sof),
        .overflow_o(overflow), .line_pixels_o(line_pixels), .line_idx_o(line_idx),
        .frame_lines_o(frame_lines), .eof_o(eof)
    );

    always @(negedge clk) if (rst_n && eof) eof_seen++;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        href = ~pol;
        y = 8'h00; uv = 8'h00;
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic frame_start();
        vsync = 1'b1;
        idle(2);
        vsync = 1'b0;
        idle(3);
    endtask

    task automatic pixel(input logic [7:0] yy, input logic [7:0] cc);
        href = pol; y = yy; uv = cc;
        @(negedge clk);
    endtask

    task automatic line_seq(input int n, input int base);
        for (int i = 0; i < n; i++) pixel(8'(base + i), 8'(8'h40 + base + i));
        idle(4);
    endtask

    function automatic logic [31:0] pair(input int a, input int b);
        return {8'(8'h40 + b), 8'(b), 8'(8'h40 + a), 8'(a)};
    endfunction

    task automatic pop(output logic [31:0] d, output logic s, output logic v);
        v = rd_valid; d = rd_data; s = rd_sof;
        if (v) begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
        end
    endtask

    task automatic t_reset();
        check("R11 valid", rd_valid, 0);
        check("R11 overflow", overflow, 0);
        check("R11 line_pixels", line_pixels, 0);
        check("R11 line_idx", line_idx, 0);
        check("R11 frame_lines", frame_lines, 0);
        check("R11 eof", eof, 0);
    endtask

    task automatic t_pack_order();
        logic [31:0] d; logic s, v;
        frame_start();
        line_seq(4, 8'h20);
        pop(d, s, v);
        check("R1 R4 first word", d, pair(8'h20, 8'h21));
        check("R6 sof first", s, 1);
        pop(d, s, v);
        check("R4 second word", d, pair(8'h22, 8'h23));
        check("R6 sof later", s, 0);
        check("R7 drained", rd_valid, 0);
    endtask

    task automatic t_blank();
        logic [31:0] d; logic s, v;
        frame_start();
        pixel(8'h30, 8'h70);
        pixel(8'h10, 8'h80);
        pixel(8'h10, 8'h81);
        idle(4);
        check("R9 blank not counted", line_pixels, 2);
        pop(d, s, v);
        check("R3 blank skipped", d, 32'h8110_7030);
        check("R3 one word only", rd_valid, 0);
    endtask

    task automatic t_polarity();
        logic [31:0] d; logic s, v;
        pol = 1'b0;
        frame_start();
        href = 1'b1; y = 8'h55; uv = 8'h66;
        @(negedge clk); @(negedge clk);
        line_seq(2, 8'h28);
        pop(d, s, v);
        check("R2 active-low word", d, pair(8'h28, 8'h29));
        check("R2 outside line ignored", rd_valid, 0);
        pol = 1'b1;
        idle(2);
    endtask

    task automatic t_odd_and_counts();
        logic [31:0] d; logic s, v;
        int e0;
        frame_start();
        e0 = eof_seen;
        line_seq(3, 8'h00 + 8'h31);
        check("R9 line pixels odd", line_pixels, 3);
        line_seq(2, 8'h38);
        check("R9 line index", line_idx, 2);
        pop(d, s, v);
        check("R5 first line pair", d, pair(8'h31, 8'h32));
        pop(d, s, v);
        check("R5 fresh pairing", d, pair(8'h38, 8'h39));
        frame_start();
        check("R10 frame lines", frame_lines, 2);
        check("R10 eof pulse", eof_seen - e0, 1);
        check("R9 cleared by sync", line_idx, 0);
        frame_start();
        check("R10 no eof on empty frame", eof_seen - e0, 1);
    endtask

    task automatic t_overflow_and_empty_read();
        logic [31:0] d; logic s, v;
        rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
        check("R7 empty read ignored", rd_valid, 0);
        frame_start();
        line_seq(12, 8'h40);
        check("R8 overflow set", overflow, 1);
        for (int k = 0; k < 4; k++) begin
            pop(d, s, v);
            check("R8 stored intact", d, pair(8'h40 + 2 * k, 8'h41 + 2 * k));
        end
        check("R7 depth words only", rd_valid, 0);
        idle(3);
        check("R8 sticky", overflow, 1);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                t_reset();
                t_pack_order();
                t_blank();
                t_polarity();
                t_odd_and_counts();
                t_overflow_and_empty_read();
            end
            begin
                repeat (20000) @(negedge clk);
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule